// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Out

This block shifts or rotates a data word by an amount held in a general register, the way a processor datapath does for a data-processing operation whose second operand is shifted by a register value. It offers four kinds of shift: logical left, logical right, arithmetic right and rotate right. It returns the shifted word, the carry-out bit and a flag. The flag tells the flag logic downstream whether that carry should be written back.

Only the low field of the amount register counts. For a 32-bit word this field is one byte. Amounts of zero, exactly the word width, and more than the word width each follow their own fixed rule for every shift kind. The block is purely combinational and has no clock or state. It sits between the register read and the ALU input.

Top module: `regshift_core`

## Requirements
- R1: Only bits [SEL_BITS-1:0] of `amount` form the effective amount n (SEL_BITS = 8 by default, so the low byte). Changing higher bits of `amount` has no effect on any output.
- R2: When n = 0, `result` equals `operand`, `carry_out` equals `carry_in` and `carry_update` is 0, for every shift kind.
- R3: Logical left (kind 2'b00). For 1 ≤ n < DW, result = operand shifted left by n with zeros filled in, and carry = operand[DW−n]. For n = DW, result = 0 and carry = operand[0]. For n > DW, result = 0 and carry = 0.
- R4: Logical right (kind 2'b01). For 1 ≤ n < DW, result = operand shifted right by n with zeros filled in, and carry = operand[n−1]. For n = DW, result = 0 and carry = operand[DW−1]. For n > DW, result = 0 and carry = 0.
- R5: Arithmetic right (kind 2'b10). For 1 ≤ n < DW, result = operand shifted right by n with copies of operand[DW−1] filled in, and carry = operand[n−1]. For n ≥ DW, every result bit and the carry equal operand[DW−1].
- R6: Rotate right (kind 2'b11). Let m = n mod DW. For m ≠ 0, result = operand rotated right by m and carry = operand[m−1]. For m = 0 with n ≠ 0, result = operand and carry = operand[DW−1].
- R7: The kind encoding is 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R8: `carry_update` is 0 exactly when n = 0 and is 1 otherwise. Whenever it is 0, `carry_out` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | DW | Word to shift |
| amount | input | AMT_W | Register holding the shift amount |
| kind | input | 2 | Shift kind select (R7 encoding) |
| carry_in | input | 1 | Current carry flag |
| result | output | DW | Shifted or rotated word |
| carry_out | output | 1 | Carry produced by the shift, or carry_in when unchanged |
| carry_update | output | 1 | High when carry_out should be written to the flag |

## Verification
The bench builds a narrow copy with DW = 8, SEL_BITS = 4 and AMT_W = 8. This makes every effective amount from 0 to 15 reachable, so the zero, in-range, exactly-width and beyond-width cases are all covered for every 8-bit operand, both carry inputs and all four kinds. A nonzero upper nibble is also applied to show that the unused amount bits are ignored. A second copy with the default 32-bit parameters is swept over walking, sign-heavy and mixed operand patterns and over amounts 0 to 40. That sweep also includes 255 and values whose low byte is zero but whose upper bits are set.

// File: rtl/regshift_core.sv
module regshift_core #(
  parameter int DW       = 32,
  parameter int AMT_W    = 32,
  parameter int SEL_BITS = 8
) (
  input  logic [DW-1:0]    operand,
  input  logic [AMT_W-1:0] amount,
  input  logic [1:0]       kind,
  input  logic             carry_in,
  output logic [DW-1:0]    result,
  output logic             carry_out,
  output logic             carry_update
);
  localparam int LOG2DW = $clog2(DW);
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;
  localparam logic [1:0] K_ROR = 2'b11;
  localparam logic [AMT_W-1:0] SEL_MASK = AMT_W'((64'd1 << SEL_BITS) - 64'd1);
  localparam logic [LOG2DW:0] DW_V = (LOG2DW+1)'(DW);

  logic [SEL_BITS-1:0] eff;
  logic [LOG2DW-1:0]   rot;
  logic [LOG2DW:0]     rot_back;
  logic [DW:0]         lsl_w;
  logic [DW:0]         lsr_w;
  logic signed [DW:0]  asr_w;
  logic [DW-1:0]       ror_r;

  assign eff      = amount[SEL_BITS-1:0];
  assign rot      = eff[LOG2DW-1:0];
  assign rot_back = DW_V - {1'b0, rot};

  // carry lands in the extra bit of each widened shift
  assign lsl_w = {1'b0, operand} << eff;
  assign lsr_w = {operand, 1'b0} >> eff;
  assign asr_w = $signed({operand, 1'b0}) >>> eff;
  assign ror_r = (operand >> rot) | (operand << rot_back);

  always_comb begin
    result       = operand;
    carry_out    = carry_in;
    carry_update = 1'b0;
    if (eff != '0) begin
      carry_update = 1'b1;
      case (kind)
        K_LSL: begin result = lsl_w[DW-1:0]; carry_out = lsl_w[DW]; end
        K_LSR: begin result = lsr_w[DW:1];   carry_out = lsr_w[0];  end
        K_ASR: begin result = asr_w[DW:1];   carry_out = asr_w[0];  end
        default: begin result = ror_r;       carry_out = ror_r[DW-1]; end
      endcase
    end
  end

  always_comb begin
    if ((amount & SEL_MASK) == '0)
      assert_zero_amt_hold_R2: assert (result == operand && carry_out == carry_in && !carry_update);
    if (!carry_update)
      assert_flag_keep_R8: assert (carry_out == carry_in);
    if (kind == K_ROR)
      assert_rot_popcount_R6: assert ($countones(result) == $countones(operand));
    if (kind == K_ASR)
      assert_asr_sign_R5: assert (result[DW-1] == operand[DW-1]);
    if (kind == K_LSL && int'(eff) > DW)
      assert_lsl_clear_R3: assert (result == '0 && carry_out == 1'b0);
    if (kind == K_LSR && int'(eff) > DW)
      assert_lsr_clear_R4: assert (result == '0 && carry_out == 1'b0);
  end
endmodule

// File: tb/test_regshift_core.sv
module test_regshift_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // narrow copy: DW=8, low nibble selects the amount
  logic [7:0] s_op, s_amt, s_res;
  logic [1:0] s_kind;
  logic       s_ci, s_co, s_cu;

  regshift_core #(.DW(8), .AMT_W(8), .SEL_BITS(4)) i_regshift_core (
    .operand(s_op), .amount(s_amt), .kind(s_kind), .carry_in(s_ci),
    .result(s_res), .carry_out(s_co), .carry_update(s_cu));

  logic [31:0] w_op, w_amt, w_res;
  logic [1:0]  w_kind;
  logic        w_ci, w_co, w_cu;

  regshift_core i_regshift_core_full (
    .operand(w_op), .amount(w_amt), .kind(w_kind), .carry_in(w_ci),
    .result(w_res), .carry_out(w_co), .carry_update(w_cu));

  // reference: kind 0 LSL, 1 LSR, 2 ASR, 3 ROR (R7)
  task automatic model(input int w, input logic [31:0] op, input int n,
                       input logic [1:0] k, input logic ci,
                       output logic [31:0] r, output logic c, output logic u);
    logic s;
    int m;
    r = '0; c = ci; u = 1'b0;
    s = op[w-1];
    if (n == 0) begin
      r = op;
      return;
    end
    u = 1'b1;
    case (k)
      2'd0: begin
        for (int i = 0; i < w; i++) if (i - n >= 0) r[i] = op[i-n];
        c = (n <= w) ? op[w-n] : 1'b0;
      end
      2'd1: begin
        for (int i = 0; i < w; i++) if (i + n < w) r[i] = op[i+n];
        c = (n <= w) ? op[n-1] : 1'b0;
      end
      2'd2: begin
        for (int i = 0; i < w; i++) r[i] = (i + n < w) ? op[i+n] : s;
        c = (n >= w) ? s : op[n-1];
      end
      default: begin
        m = n % w;
        for (int i = 0; i < w; i++) r[i] = op[(i+m)%w];
        c = (m == 0) ? s : op[m-1];
      end
    endcase
  endtask

  function automatic string tag(input logic [1:0] k, input int n, input bit hi);
    if (n == 0) return "R2";
    if (hi) return "R1";
    case (k)
      2'd0: return "R3 R7";
      2'd1: return "R4 R7";
      2'd2: return "R5 R7";
      default: return "R6 R7";
    endcase
  endfunction

  task automatic run_small(input logic [7:0] op, input logic [7:0] amt,
                           input logic [1:0] k, input logic ci);
    logic [31:0] er;
    logic ec, eu;
    @(posedge clk);
    s_op = op; s_amt = amt; s_kind = k; s_ci = ci;
    @(negedge clk);
    model(8, {24'd0, op}, int'(amt[3:0]), k, ci, er, ec, eu);
    vectors++;
    if (s_res !== er[7:0] || s_co !== ec || s_cu !== eu) begin
      fails++;
      $display("FAIL %s%s op=%h amt=%h kind=%0d ci=%0b got res=%h c=%0b u=%0b exp res=%h c=%0b u=%0b",
               tag(k, int'(amt[3:0]), amt[7:4] != 0), (s_cu !== eu) ? " R8" : "",
               op, amt, k, ci, s_res, s_co, s_cu, er[7:0], ec, eu);
    end
  endtask

  task automatic run_wide(input logic [31:0] op, input logic [31:0] amt,
                          input logic [1:0] k, input logic ci);
    logic [31:0] er;
    logic ec, eu;
    @(posedge clk);
    w_op = op; w_amt = amt; w_kind = k; w_ci = ci;
    @(negedge clk);
    model(32, op, int'(amt[7:0]), k, ci, er, ec, eu);
    vectors++;
    if (w_res !== er || w_co !== ec || w_cu !== eu) begin
      fails++;
      $display("FAIL %s%s op=%h amt=%h kind=%0d ci=%0b got res=%h c=%0b u=%0b exp res=%h c=%0b u=%0b",
               tag(k, int'(amt[7:0]), amt[31:8] != 0), (w_cu !== eu) ? " R8" : "",
               op, amt, k, ci, w_res, w_co, w_cu, er, ec, eu);
    end
  endtask

  initial begin
    logic [31:0] pats [6];
    logic [31:0] amts [5];
    s_op = '0; s_amt = '0; s_kind = '0; s_ci = 1'b1;
    w_op = '0; w_amt = '0; w_kind = '0; w_ci = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // quiescent state with zero amount: R2 and R8
    vectors++;
    if (s_res !== 8'h00 || s_co !== 1'b1 || s_cu !== 1'b0) begin
      fails++;
      $display("FAIL R2 R8 idle got res=%h c=%0b u=%0b exp res=00 c=1 u=0", s_res, s_co, s_cu);
    end

    // exhaustive narrow sweep; upper nibble 0 then 9 (R1)
    for (int hi = 0; hi < 2; hi++)
      for (int k = 0; k < 4; k++)
        for (int ci = 0; ci < 2; ci++)
          for (int a = 0; a < 16; a++)
            for (int o = 0; o < 256; o++)
              run_small(8'(o), {(hi != 0) ? 4'h9 : 4'h0, 4'(a)}, 2'(k), 1'(ci));

    // wide sweep at default parameters
    pats[0] = 32'h8000_0001; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h7FFF_FFFE;
    pats[3] = 32'hA5C3_0F96; pats[4] = 32'h0000_0001; pats[5] = 32'h8000_0000;
    amts[0] = 32'd255; amts[1] = 32'h0000_0100; amts[2] = 32'hFFFF_FF00;
    amts[3] = 32'h1234_5620; amts[4] = 32'h0000_0140;
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 4; k++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int a = 0; a <= 40; a++) run_wide(pats[p], 32'(a), 2'(k), 1'(ci));
          for (int a = 0; a < 5; a++) run_wide(pats[p], amts[a], 2'(k), 1'(ci));
        end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule